// File: doc/BRIEF.md
# Sensor-Prioritized Junction Light Controller

This block sequences the signal heads at a junction where a main road meets a side road. It drives four heads. Two face the main road and two face the side road. With no traffic on the side road, the two main heads take turns. Each main phase lasts a fixed number of one-second ticks and ends with a short amber interval. Two motion-sensor lines can each ask for a side-road phase. A request is remembered while a main phase runs. Once that main head has gone red, the matching side head runs a phase of the same length. The main alternation then resumes.

The phase timer counts down from the phase length to one, stepping once per tick. Its value is presented as two BCD digits for a numeric display. The one-second tick comes from outside the block, as a one-clock pulse. The sensor lines arrive already clean and synchronous.

Top module: `junction_light_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and for the one cycle after its release, every head shows red and the count reads 12. On the next cycle, main head 0 turns green with a count of 12.
- R2: With no side request, phases alternate main head 0, main head 1, main head 0, and so on. Each phase lasts exactly 12 tick periods.
- R3: Lamp vectors are indexed as follows: bit 0 is main head 0, bit 1 is main head 1, bit 2 is side head 0 and bit 3 is side head 1. In every cycle, each head shows exactly one of red, amber or green, and at most one head is green. The head that owns the phase is green while the count is above 2 and amber while it is 2 or 1. Every other head is red.
- R4: The count drops by one on each tick and holds between ticks. The tick that arrives while the count is 1 reloads the count to 12 and ends the phase.
- R5: `cnt_tens` and `cnt_units` give the count in BCD. The tens digit is 0 or 1 and the units digit is 0 to 9.
- R6: A sensor 0 pulse seen in any cycle of a main phase makes side head 0 run the next phase. The main head that did not run before the insertion follows it.
- R7: When both requests are pending at the end of a main phase, side head 0 runs first and side head 1 runs next. Main alternation then resumes with the main head other than the one that ran before the insertion.
- R8: A sensor 1 request alone inserts one side head 1 phase, followed by the other main head.
- R9: Sensor activity during a side phase is ignored. It raises no request and changes no phase.
- R10: A request is cleared when its side phase starts, so one sensor pulse inserts that side phase only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock pulse per second |
| sense_side0 | input | 1 | Motion sensor for side head 0 |
| sense_side1 | input | 1 | Motion sensor for side head 1 |
| lamp_red | output | 4 | Red drive per head |
| lamp_yel | output | 4 | Amber drive per head |
| lamp_grn | output | 4 | Green drive per head |
| cnt_tens | output | 4 | BCD tens digit of the countdown |
| cnt_units | output | 4 | BCD units digit of the countdown |

## Verification
The bench uses the default parameters: a phase of 12 ticks with 2 amber ticks. This lets the count cross the tens boundary, from 12 down through 10 to 9, in every phase, so both BCD digits are exercised. A tick arrives every second clock, so a whole phase takes 24 cycles. This keeps runs of ten or more phases short, which is enough to cover single requests, requests from both sensors, a request ignored during a side phase, and a reset in the middle of a run.

// File: rtl/jlc_pkg.sv
package jlc_pkg;

    localparam int HEADS = 4;

    typedef enum logic [2:0] {
        PH_BOOT   = 3'd0,
        PH_MAJOR0 = 3'd1,
        PH_MAJOR1 = 3'd2,
        PH_MINOR0 = 3'd3,
        PH_MINOR1 = 3'd4
    } phase_e;

    // Lamp bit owned by each phase.
    function automatic logic [1:0] head_of(phase_e p);
        case (p)
            PH_MAJOR1: head_of = 2'd1;
            PH_MINOR0: head_of = 2'd2;
            PH_MINOR1: head_of = 2'd3;
            default:   head_of = 2'd0;
        endcase
    endfunction

    function automatic logic is_major(phase_e p);
        is_major = (p == PH_MAJOR0) || (p == PH_MAJOR1);
    endfunction

endpackage

// File: rtl/jlc_countdown.sv
module jlc_countdown #(
    parameter int PHASE_TICKS = 12,
    parameter int CW          = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          hold,
    output logic [CW-1:0] cnt,
    output logic          expire
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (tick && !hold) begin
            if (tmr_q.cnt == CW'(1)) begin
                tmr_d.cnt = CW'(PHASE_TICKS);
                expire    = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '{cnt: CW'(PHASE_TICKS)};
        else     tmr_q <= tmr_d;
    end

    assign cnt = tmr_q.cnt;

    assert_expire_reload_R4: assert property (@(posedge clk) disable iff (rst)
        expire |=> (tmr_q.cnt == CW'(PHASE_TICKS)));

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tmr_q.cnt));

    assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
        (tmr_q.cnt >= CW'(1)) && (tmr_q.cnt <= CW'(PHASE_TICKS)));

endmodule

// File: rtl/jlc_phase_seq.sv
module jlc_phase_seq
    import jlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    input  logic   sense0,
    input  logic   sense1,
    output phase_e phase
);

    typedef struct packed {
        phase_e phase;
        logic   pend0;
        logic   pend1;
        logic   last_major;   // 1: main head 1 ran just before the insertion
    } seq_t;

    seq_t   seq_d, seq_q;
    logic   req0, req1;
    phase_e resume;

    always_comb begin
        seq_d  = seq_q;
        req0   = seq_q.pend0 | sense0;
        req1   = seq_q.pend1 | sense1;
        resume = seq_q.last_major ? PH_MAJOR0 : PH_MAJOR1;
        case (seq_q.phase)
            PH_BOOT: seq_d.phase = PH_MAJOR0;
            PH_MAJOR0, PH_MAJOR1: begin
                seq_d.pend0 = req0;
                seq_d.pend1 = req1;
                if (expire) begin
                    if (req0) begin
                        seq_d.phase      = PH_MINOR0;
                        seq_d.pend0      = 1'b0;
                        seq_d.last_major = (seq_q.phase == PH_MAJOR1);
                    end else if (req1) begin
                        seq_d.phase      = PH_MINOR1;
                        seq_d.pend1      = 1'b0;
                        seq_d.last_major = (seq_q.phase == PH_MAJOR1);
                    end else begin
                        seq_d.phase = (seq_q.phase == PH_MAJOR0) ? PH_MAJOR1 : PH_MAJOR0;
                    end
                end
            end
            PH_MINOR0: begin
                if (expire) begin
                    if (seq_q.pend1) begin
                        seq_d.phase = PH_MINOR1;
                        seq_d.pend1 = 1'b0;
                    end else begin
                        seq_d.phase = resume;
                    end
                end
            end
            PH_MINOR1: begin
                if (expire) seq_d.phase = resume;
            end
            default: seq_d.phase = PH_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '{phase: PH_BOOT, pend0: 1'b0, pend1: 1'b0, last_major: 1'b0};
        else     seq_q <= seq_d;
    end

    assign phase = seq_q.phase;

    assert_boot_to_major0_R1: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_BOOT) |=> (seq_q.phase == PH_MAJOR0));

    assert_plain_alternation_R2: assert property (@(posedge clk) disable iff (rst)
        ((seq_q.phase == PH_MAJOR0) && expire && !seq_q.pend0 && !seq_q.pend1 && !sense0 && !sense1)
        |=> (seq_q.phase == PH_MAJOR1));

    assert_side0_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (is_major(seq_q.phase) && expire && (seq_q.pend0 || sense0)) |=> (seq_q.phase == PH_MINOR0));

    assert_side1_follows_R7: assert property (@(posedge clk) disable iff (rst)
        ((seq_q.phase == PH_MINOR0) && expire && seq_q.pend1) |=> (seq_q.phase == PH_MINOR1));

    assert_side_ignores_sensors_R9: assert property (@(posedge clk) disable iff (rst)
        (!is_major(seq_q.phase) && !expire) |=> ($stable(seq_q.pend0) && $stable(seq_q.pend1)));

    assert_request_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_MINOR0) |-> !seq_q.pend0);

endmodule

// File: rtl/jlc_lamp_drive.sv
module jlc_lamp_drive
    import jlc_pkg::*;
#(
    parameter int CW          = 4,
    parameter int AMBER_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic [CW-1:0]    cnt,
    output logic [HEADS-1:0] red,
    output logic [HEADS-1:0] yel,
    output logic [HEADS-1:0] grn
);

    logic amber;
    assign amber = (cnt <= CW'(AMBER_TICKS));

    for (genvar h = 0; h < HEADS; h++) begin : g_head
        logic owns;
        assign owns   = (phase != PH_BOOT) && (head_of(phase) == 2'(h));
        assign grn[h] = owns && !amber;
        assign yel[h] = owns && amber;
        assign red[h] = !owns;

        assert_one_aspect_R3: assert property (@(posedge clk) disable iff (rst)
            $countones({red[h], yel[h], grn[h]}) == 1);
    end

    assert_single_green_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grn));

endmodule

// File: rtl/jlc_bcd_split.sv
module jlc_bcd_split #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] bin,
    output logic [3:0]    tens,
    output logic [3:0]    units
);

    int unsigned val;

    always_comb begin
        val   = 32'(bin);
        tens  = 4'(val / 10);
        units = 4'(val % 10);
    end

    assert_bcd_digits_R5: assert property (@(posedge clk) disable iff (rst)
        (units <= 4'd9) && (tens <= 4'd9));

endmodule

// File: rtl/junction_light_ctrl.sv
module junction_light_ctrl
    import jlc_pkg::*;
#(
    parameter int PHASE_TICKS = 12,
    parameter int AMBER_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sense_side0,
    input  logic       sense_side1,
    output logic [3:0] lamp_red,
    output logic [3:0] lamp_yel,
    output logic [3:0] lamp_grn,
    output logic [3:0] cnt_tens,
    output logic [3:0] cnt_units
);

    localparam int CW = $clog2(PHASE_TICKS + 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          expire;

    jlc_countdown #(.PHASE_TICKS(PHASE_TICKS), .CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .hold   (phase == PH_BOOT),
        .cnt    (cnt),
        .expire (expire)
    );

    jlc_phase_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .sense0 (sense_side0),
        .sense1 (sense_side1),
        .phase  (phase)
    );

    jlc_lamp_drive #(.CW(CW), .AMBER_TICKS(AMBER_TICKS)) u_lamps (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .cnt   (cnt),
        .red   (lamp_red),
        .yel   (lamp_yel),
        .grn   (lamp_grn)
    );

    jlc_bcd_split #(.CW(CW)) u_bcd (
        .clk   (clk),
        .rst   (rst),
        .bin   (cnt),
        .tens  (cnt_tens),
        .units (cnt_units)
    );

    assert_boot_all_red_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BOOT) |-> ((&lamp_red) && (cnt == CW'(PHASE_TICKS))));

endmodule

// File: tb/junction_light_ctrl_tb.sv
module junction_light_ctrl_tb;

    typedef struct {
        logic [11:0] lamps;   // {red, yel, grn}
        int          count;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       s0 = 1'b0;
    logic       s1 = 1'b0;
    logic [3:0] lamp_red, lamp_yel, lamp_grn, cnt_tens, cnt_units;

    int   checks = 0;
    int   fails  = 0;
    exp_t q[$];
    bit   done = 1'b0;

    // Reference model: 0 boot, 1 main0, 2 main1, 3 side0, 4 side1
    int m_ph = 0, m_cnt = 12, m_last = 1;
    bit m_p0 = 0, m_p1 = 0;

    always #5 clk = ~clk;

    junction_light_ctrl u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .sense_side0(s0), .sense_side1(s1),
        .lamp_red(lamp_red), .lamp_yel(lamp_yel), .lamp_grn(lamp_grn),
        .cnt_tens(cnt_tens), .cnt_units(cnt_units)
    );

    function automatic int other_main(int m);
        return (m == 1) ? 2 : 1;
    endfunction

    function automatic logic [11:0] model_lamps();
        logic [3:0] r, y, g;
        r = 4'hF; y = 4'h0; g = 4'h0;
        if (m_ph != 0) begin
            r[m_ph-1] = 1'b0;
            if (m_cnt <= 2) y[m_ph-1] = 1'b1;
            else            g[m_ph-1] = 1'b1;
        end
        return {r, y, g};
    endfunction

    task automatic model_end_phase();
        m_cnt = 12;
        if (m_ph == 1 || m_ph == 2) begin
            if (m_p0)      begin m_last = m_ph; m_ph = 3; m_p0 = 0; end
            else if (m_p1) begin m_last = m_ph; m_ph = 4; m_p1 = 0; end
            else           m_ph = other_main(m_ph);
        end else if (m_ph == 3) begin
            if (m_p1) begin m_ph = 4; m_p1 = 0; end
            else      m_ph = other_main(m_last);
        end else begin
            m_ph = other_main(m_last);
        end
    endtask

    // Driver: one clock cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(bit r, bit t, bit a, bit b, string tag);
        exp_t e;
        rst = r; tick = t; s0 = a; s1 = b;
        if (r) begin
            m_ph = 0; m_cnt = 12; m_p0 = 0; m_p1 = 0; m_last = 1;
        end else if (m_ph == 0) begin
            m_ph = 1; m_cnt = 12;
        end else begin
            if (m_ph == 1 || m_ph == 2) begin
                m_p0 = m_p0 | a;
                m_p1 = m_p1 | b;
            end
            if (t) begin
                if (m_cnt == 1) model_end_phase();
                else            m_cnt = m_cnt - 1;
            end
        end
        e.lamps = model_lamps();
        e.count = m_cnt;
        e.tag   = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run_ticks(int n, bit a, bit b, string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1, a, b, tag);
            step(1'b0, 1'b0, a, b, tag);
        end
    endtask

    // Monitor: compares mid-cycle after each active edge
    initial begin
        exp_t e;
        int   got;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if ({lamp_red, lamp_yel, lamp_grn} !== e.lamps) begin
                    fails++;
                    $display("FAIL %s lamps actual=%h expected=%h at %0t", e.tag,
                             {lamp_red, lamp_yel, lamp_grn}, e.lamps, $time);
                end
                got = int'(cnt_tens) * 10 + int'(cnt_units);
                checks++;
                if (got != e.count) begin
                    fails++;
                    $display("FAIL R4 count actual=%0d expected=%0d at %0t", got, e.count, $time);
                end
                checks++;
                if (cnt_tens > 4'd1 || cnt_units > 4'd9 ||
                    cnt_tens != 4'(e.count / 10) || cnt_units != 4'(e.count % 10)) begin
                    fails++;
                    $display("FAIL R5 bcd actual=%0d_%0d expected=%0d_%0d at %0t",
                             cnt_tens, cnt_units, e.count / 10, e.count % 10, $time);
                end
                checks++;
                if ($countones(lamp_grn) > 1) begin
                    fails++;
                    $display("FAIL R3 greens actual=%b expected=at most one", lamp_grn);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state, boot cycle, first main phase
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1");   // boot cycle ignores tick
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R2: plain alternation main0 -> main1 -> main0
        run_ticks(24, 1'b0, 1'b0, "R2");
        // R6: sensor 0 early in main0, then side0, then main1
        run_ticks(3, 1'b1, 1'b0, "R6");
        run_ticks(9, 1'b0, 1'b0, "R6");
        // R9: sensor 1 and 0 during side0 ignored, main1 follows
        run_ticks(4, 1'b1, 1'b1, "R9");
        run_ticks(8, 1'b0, 1'b0, "R9");
        // R7: both sensors in main1 -> side0 -> side1 -> main0
        run_ticks(2, 1'b1, 1'b1, "R7");
        run_ticks(34, 1'b0, 1'b0, "R7");
        // R8: sensor 1 alone in main0 -> side1 -> main1
        run_ticks(2, 1'b0, 1'b1, "R8");
        run_ticks(22, 1'b0, 1'b0, "R8");
        // R10: no repeat insertion; main1 -> main0
        run_ticks(16, 1'b0, 1'b0, "R10");
        // R1: reset mid-run
        step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        run_ticks(13, 1'b0, 1'b0, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule